// File: doc/BRIEF.md
# Microwire Serial EEPROM Slave

This block is the device side of a small serial EEPROM. A host frames each transaction with a chip-select input and shifts bits in on a data input, one per rising edge of a serial clock. Every transaction begins with a start bit of 1, followed by a two-bit opcode and an address. Programming transactions add a data field. The block supports four kinds of work: reading a location, writing it, erasing it, and erasing or writing the whole array. Read data streams out on a single data output and keeps flowing across successive locations for as long as chip select stays high. An organization input selects 16-bit words or 8-bit bytes. The choice changes the width of both the address field and the data field.

Storage is a register array of `TOTAL_BITS` cells, organized as `TOTAL_BITS/WORD_W` words of `WORD_W` bits. Programming is self-timed. A counter running on the system clock stands in for the nonvolatile cell time, and the result is committed to the array when that count ends. While programming is in progress the data output reports status whenever chip select is high.

The control state machine has eight states:
- ST_IDLE waits for a start bit and goes to ST_OPC.
- ST_OPC takes in the opcode, then goes to ST_ADDR.
- ST_ADDR takes in the address. It then moves to ST_READ for a read, to ST_DATA for a write or write-all, to ST_BUSY for an erase or erase-all, or to ST_SKIP for a mode instruction or any programming request made while writes are disabled.
- ST_DATA takes in the data field, then goes to ST_BUSY.
- ST_READ streams data out.
- ST_SKIP swallows bits until chip select goes low.
- ST_BUSY runs the program counter and goes to ST_READY when the count ends.
- ST_READY shows ready and, like ST_IDLE, accepts the next start bit.

Chip select going low returns ST_OPC, ST_ADDR, ST_DATA, ST_READ and ST_SKIP to ST_IDLE. It does not affect ST_BUSY or ST_READY.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, dout is 0 even with chip select high, and every array location reads as all ones.
- R2: Read (opcode 10, word mode) uses these fields in order: start bit 1, opcode MSB first, 8 address bits MSB first. After the last address bit the output shows a 0 dummy bit. Each following rising serial clock edge then presents the next of the 16 data bits, MSB first.
- R3: While chip select stays high after a read word, the following locations stream out without another dummy bit. The address wraps from the last location to 0.
- R4: With org low (byte mode), addresses are 9 bits and data is 8 bits. Byte address bit 0 selects the low (0) or high (1) half of word address[8:1]. The org value is taken at the start bit, and later changes of the pin within that transaction have no effect.
- R5: Write (opcode 01) stores the data field (16 bits MSB first, or 8 in byte mode). The new value replaces the old content whatever the old bits were.
- R6: Erase (opcode 11) sets the addressed location to all ones.
- R7: Opcode 00 decodes the two top address bits. The value 11 enables writes and 00 disables them. The value 01 is write-all and takes a data field that lands in every word. The value 10 is erase-all and sets every word to all ones.
- R8: Write, erase, write-all and erase-all have no effect and start no program cycle unless writes are enabled. Writes are disabled after reset.
- R9: From the last bit of a programming instruction, the program runs for PROG_CYCLES system clocks. During that time dout reads 0 whenever chip select is high. After completion dout reads 1 whenever chip select is high, until the next start bit.
- R10: A started program cycle completes with chip select low and the serial clock stopped.
- R11: Chip select falling before an instruction is complete discards it. No location changes and no program cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial inputs are sampled on it |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Chip select, high frames a transaction |
| sk | input | 1 | Serial clock; its rising edge shifts a bit |
| di | input | 1 | Serial data in |
| org | input | 1 | 1 selects 16-bit words, 0 selects 8-bit bytes |
| dout | output | 1 | Serial read data or busy/ready status |

## Verification
Reads are issued in word mode and in byte mode, and streaming reads cross the top of the array. These runs separate the dummy-bit placement, the increment and wrap logic, and the byte-lane choice. Each transaction toggles the org pin right after its start bit, which shows whether the width is taken only at the start bit. Writes are applied over locations that already hold non-erased patterns, which separates a true replacing write from one that can only clear bits. Aborted transactions and disabled-write transactions are followed by status polling and readback, which shows that no program cycle started and no location changed.

// File: rtl/mw_pkg.sv
package mw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_SKIP,
        ST_BUSY,
        ST_READY
    } mw_state_t;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] EXT_WDIS = 2'b00;
    localparam logic [1:0] EXT_WALL = 2'b01;
    localparam logic [1:0] EXT_EALL = 2'b10;
    localparam logic [1:0] EXT_WEN  = 2'b11;
endpackage

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    assign done = busy && (cnt == CW'(CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n) start |-> !busy); // R9
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R9
endmodule

// File: rtl/mw_array.sv
module mw_array #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [WORD_W-1:0]        rd_data,
    input  logic                     wr_en,
    input  logic                     wr_all,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic [WORD_W-1:0]        wr_mask
);
    localparam int AW = $clog2(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];

    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_all || wr_addr == AW'(i))
                    mem[i] <= (mem[i] & ~wr_mask) | (wr_data & wr_mask);
            end
        end
    end

    AST_ALL_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_all) |-> (wr_mask == '1)); // R7
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int TOTAL_BITS  = 4096,
    parameter int PROG_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    input  logic org,
    output logic dout
);
    localparam int BYTE_W = WORD_W / 2;
    localparam int DEPTH  = TOTAL_BITS / WORD_W;
    localparam int AW_W   = $clog2(DEPTH);
    localparam int AW_B   = AW_W + 1;
    localparam int CNT_W  = $clog2(WORD_W + AW_B);

    mw_state_t state, nstate;

    logic              sk_q, bit_ev;
    logic [1:0]        opc, ext_op;
    logic              org_q, we_en;
    logic [AW_B-1:0]   addr_sh, addr_full, ptr, ptr_inc, look_addr;
    logic [WORD_W-1:0] dat_sh, data_full, rd_sh, look_aligned, arr_rd_data;
    logic [CNT_W-1:0]  bitcnt, aw_len, dw_len;
    logic              last_addr, last_data, rd_bit;
    logic [AW_W-1:0]   arr_rd_addr, pend_addr;
    logic [WORD_W-1:0] pend_data, pend_mask, lane_mask;
    logic              pend_all, prog_start, tmr_busy, tmr_done;

    assign bit_ev    = sk & ~sk_q & cs;
    assign aw_len    = org_q ? CNT_W'(AW_W) : CNT_W'(AW_B);
    assign dw_len    = org_q ? CNT_W'(WORD_W) : CNT_W'(BYTE_W);
    assign last_addr = (bitcnt == aw_len - 1'b1);
    assign last_data = (bitcnt == dw_len - 1'b1);
    assign addr_full = {addr_sh[AW_B-2:0], di};
    assign data_full = {dat_sh[WORD_W-2:0], di};
    assign ext_op    = org_q ? addr_full[AW_W-1 -: 2] : addr_full[AW_B-1 -: 2];
    assign ptr_inc   = org_q ? {1'b0, ptr[AW_W-1:0] + 1'b1} : ptr + 1'b1;
    assign look_addr = (state == ST_ADDR) ? addr_full : ptr_inc;
    assign arr_rd_addr = org_q ? look_addr[AW_W-1:0] : look_addr[AW_B-1:1];
    assign lane_mask = addr_full[0] ? {{BYTE_W{1'b1}}, {BYTE_W{1'b0}}}
                                    : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};

    always_comb begin
        if (org_q)
            look_aligned = arr_rd_data;
        else if (look_addr[0])
            look_aligned = {arr_rd_data[WORD_W-1 -: BYTE_W], {BYTE_W{1'b0}}};
        else
            look_aligned = {arr_rd_data[BYTE_W-1:0], {BYTE_W{1'b0}}};
    end

    // next-state logic
    always_comb begin
        nstate = state;
        if (!cs && (state == ST_OPC || state == ST_ADDR || state == ST_DATA ||
                    state == ST_READ || state == ST_SKIP)) begin
            nstate = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_READY: if (bit_ev && di) nstate = ST_OPC;
                ST_OPC:  if (bit_ev && bitcnt == CNT_W'(1)) nstate = ST_ADDR;
                ST_ADDR: if (bit_ev && last_addr) begin
                    unique case (opc)
                        OP_READ:  nstate = ST_READ;
                        OP_WRITE: nstate = we_en ? ST_DATA : ST_SKIP;
                        OP_ERASE: nstate = we_en ? ST_BUSY : ST_SKIP;
                        default: begin
                            if (ext_op == EXT_WALL)      nstate = we_en ? ST_DATA : ST_SKIP;
                            else if (ext_op == EXT_EALL) nstate = we_en ? ST_BUSY : ST_SKIP;
                            else                         nstate = ST_SKIP;
                        end
                    endcase
                end
                ST_DATA: if (bit_ev && last_data) nstate = ST_BUSY;
                ST_BUSY: if (tmr_done) nstate = ST_READY;
                default: ;
            endcase
        end
    end

    assign prog_start = (nstate == ST_BUSY) && (state != ST_BUSY);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sk_q <= 1'b0; opc <= '0; org_q <= 1'b1; we_en <= 1'b0;
            addr_sh <= '0; dat_sh <= '0; bitcnt <= '0; ptr <= '0;
            rd_sh <= '0; rd_bit <= 1'b0;
            pend_addr <= '0; pend_data <= '1; pend_mask <= '1; pend_all <= 1'b0;
        end else begin
            sk_q <= sk;
            unique case (state)
                ST_IDLE, ST_READY: if (nstate == ST_OPC) begin
                    opc <= '0; bitcnt <= '0; addr_sh <= '0; org_q <= org;
                end
                ST_OPC: if (bit_ev) begin
                    opc    <= {opc[0], di};
                    bitcnt <= (bitcnt == CNT_W'(1)) ? '0 : bitcnt + 1'b1;
                end
                ST_ADDR: if (bit_ev) begin
                    addr_sh <= addr_full;
                    bitcnt  <= bitcnt + 1'b1;
                    if (last_addr) begin
                        bitcnt    <= '0;
                        ptr       <= addr_full;
                        rd_sh     <= look_aligned;
                        rd_bit    <= 1'b0;
                        pend_addr <= org_q ? addr_full[AW_W-1:0] : addr_full[AW_B-1:1];
                        pend_mask <= (org_q || opc == OP_EXT) ? '1 : lane_mask;
                        pend_all  <= (opc == OP_EXT);
                        pend_data <= '1;
                        if (opc == OP_EXT && ext_op == EXT_WEN)  we_en <= 1'b1;
                        if (opc == OP_EXT && ext_op == EXT_WDIS) we_en <= 1'b0;
                    end
                end
                ST_DATA: if (bit_ev) begin
                    dat_sh <= data_full;
                    bitcnt <= bitcnt + 1'b1;
                    if (last_data)
                        pend_data <= org_q ? data_full
                                           : {data_full[BYTE_W-1:0], data_full[BYTE_W-1:0]};
                end
                ST_READ: if (bit_ev) begin
                    rd_bit <= rd_sh[WORD_W-1];
                    if (last_data) begin
                        bitcnt <= '0;
                        ptr    <= ptr_inc;
                        rd_sh  <= look_aligned;
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                        rd_sh  <= rd_sh << 1;
                    end
                end
                default: ;
            endcase
        end
    end

    // output logic
    always_comb begin
        unique case (state)
            ST_READ:  dout = cs & rd_bit;
            ST_READY: dout = cs;
            default:  dout = 1'b0;
        endcase
    end

    mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (prog_start),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    mw_array #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (arr_rd_addr),
        .rd_data (arr_rd_data),
        .wr_en   (tmr_done),
        .wr_all  (pend_all),
        .wr_addr (pend_addr),
        .wr_data (pend_data),
        .wr_mask (pend_mask)
    );

    AST_BUSY_TIMER: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_BUSY) |-> tmr_busy); // R9
    AST_PROG_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n) prog_start |-> we_en); // R8
    AST_BUSY_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_BUSY && !tmr_done) |=> (state == ST_BUSY)); // R10
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!cs && (state == ST_OPC || state == ST_ADDR || state == ST_DATA || state == ST_SKIP)) |=> (state == ST_IDLE)); // R11
    AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_ADDR && nstate == ST_READ) |=> !dout); // R2
endmodule

// File: tb/tb_mw_eeprom.sv
module tb_mw_eeprom;
    localparam int PROG = 40;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
    logic dout;
    always #5 clk = ~clk;

    mw_eeprom #(.WORD_W(16), .TOTAL_BITS(4096), .PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org), .dout(dout)
    );

    typedef struct { logic val; string req; } exp_t;
    exp_t exp_q[$];
    logic [15:0] mdl [256];
    int checks = 0, errors = 0;
    bit tb_we = 1'b0, finished = 1'b0;

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor: compares dout against queued expectations
    always @(negedge clk) begin
        exp_t e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            checks++;
            if (dout !== e.val) begin
                errors++;
                $display("FAIL %s dout=%b expected=%b", e.req, dout, e.val);
            end
        end
    end

    task automatic chk(logic [31:0] act, logic [31:0] exp, string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one serial bit; optional expected dout after the rising edge
    task automatic sbit(logic d, bit expv = 1'b0, logic ev = 1'b0, string req = "");
        di = d; sk = 1'b0; tick(4);
        sk = 1'b1; tick(2);
        if (expv) exp_q.push_back('{ev, req});
        tick(2); sk = 1'b0;
    endtask

    task automatic end_cs();
        cs = 1'b0; tick(4);
    endtask

    task automatic send_head(bit word, logic [1:0] op, logic [8:0] a, bit rd);
        int aw = word ? 8 : 9;
        org = word; cs = 1'b1; tick(2);
        sbit(1'b1);
        org = ~word; // R4: pin change after start bit must not matter
        sbit(op[1]); sbit(op[0]);
        for (int i = aw - 1; i >= 0; i--)
            sbit(a[i], rd && i == 0, 1'b0, "R2 dummy bit");
    endtask

    function automatic logic [15:0] mdl_get(bit word, int p);
        if (word) return mdl[p % 256];
        return (p % 2) ? {8'h00, mdl[(p % 512) / 2][15:8]} : {8'h00, mdl[(p % 512) / 2][7:0]};
    endfunction

    task automatic do_read(bit word, int a, int n, string req);
        int dw = word ? 16 : 8;
        int p = a;
        send_head(word, 2'b10, 9'(a), 1'b1);
        for (int k = 0; k < n; k++) begin
            logic [15:0] v = mdl_get(word, p);
            for (int b = dw - 1; b >= 0; b--) sbit(1'b0, 1'b1, v[b], req);
            p = word ? (p + 1) % 256 : (p + 1) % 512;
        end
        end_cs();
    endtask

    task automatic prog_wait(bit runs, string req);
        cs = 1'b0; tick(3);
        cs = 1'b1; tick(2);
        chk(32'(dout), 32'h0, {"R9 busy status ", req});
        cs = 1'b0; tick(3);               // R10: serial clock idle, select toggled
        cs = 1'b1; tick(PROG + 10);
        chk(32'(dout), runs ? 32'h1 : 32'h0, {"R10 ready after program ", req});
        end_cs();
    endtask

    task automatic do_write(bit word, int a, logic [15:0] d, string req);
        logic [8:0] aa = 9'(a);
        int dw = word ? 16 : 8;
        send_head(word, 2'b01, aa, 1'b0);
        for (int b = dw - 1; b >= 0; b--) sbit(d[b]);
        prog_wait(tb_we, req);
        if (tb_we) begin
            if (word)       mdl[aa[7:0]] = d;
            else if (aa[0]) mdl[aa[8:1]][15:8] = d[7:0];
            else            mdl[aa[8:1]][7:0] = d[7:0];
        end
    endtask

    task automatic do_erase(int a);
        send_head(1'b1, 2'b11, 9'(a), 1'b0);
        prog_wait(tb_we, "R6");
        if (tb_we) mdl[a % 256] = 16'hFFFF;
    endtask

    task automatic do_ext(logic [1:0] sub, logic [15:0] d);
        send_head(1'b1, 2'b00, {1'b0, sub, 6'h0}, 1'b0);
        if (sub == 2'b11) begin tb_we = 1'b1; end_cs(); end
        else if (sub == 2'b00) begin tb_we = 1'b0; end_cs(); end
        else begin
            if (sub == 2'b01) for (int b = 15; b >= 0; b--) sbit(d[b]);
            prog_wait(tb_we, "R7");
            if (tb_we) for (int i = 0; i < 256; i++) mdl[i] = (sub == 2'b01) ? d : 16'hFFFF;
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mdl[i] = 16'hFFFF;
        tick(5); rst_n = 1'b1; tick(2);
        cs = 1'b1; tick(2);
        chk(32'(dout), 32'h0, "R1 dout after reset");
        end_cs();
        do_read(1'b1, 5, 1, "R1 erased array");

        do_write(1'b1, 3, 16'h1234, "R8");     // disabled: ignored
        do_read(1'b1, 3, 1, "R8 write ignored");
        do_erase(9);                           // disabled erase, status stays 0 (R8)

        do_ext(2'b11, 16'h0);                  // R7 enable
        do_write(1'b1, 3, 16'hA5C3, "R5");
        do_read(1'b1, 3, 1, "R2 R5 word read");
        do_write(1'b1, 3, 16'h5A3C, "R5");     // replace, not AND
        do_read(1'b1, 3, 1, "R5 replace");

        do_write(1'b1, 255, 16'h0F0F, "R5");
        do_write(1'b1, 0, 16'h1111, "R5");
        do_read(1'b1, 254, 4, "R3 stream wrap");

        do_write(1'b0, 7, 16'h009E, "R4");
        do_read(1'b0, 6, 3, "R4 byte stream");
        do_read(1'b0, 511, 2, "R3 R4 byte wrap");
        do_read(1'b1, 3, 1, "R4 byte lane");

        do_erase(3);
        do_read(1'b1, 2, 3, "R6 erase");

        // R11 abort inside address field
        cs = 1'b1; tick(2); sbit(1'b1); sbit(1'b0); sbit(1'b1);
        sbit(1'b0); sbit(1'b0); sbit(1'b1); end_cs();
        // R11 abort inside data field of a write to 0
        send_head(1'b1, 2'b01, 9'd0, 1'b0);
        for (int b = 0; b < 10; b++) sbit(1'b0);
        end_cs();
        cs = 1'b1; tick(PROG + 10);
        chk(32'(dout), 32'h0, "R11 no program after abort");
        end_cs();
        do_read(1'b1, 0, 2, "R11 location unchanged");

        do_ext(2'b01, 16'h6B6B);               // R7 write-all
        do_read(1'b1, 200, 1, "R7 write-all");
        do_read(1'b1, 0, 1, "R7 write-all");
        do_ext(2'b10, 16'h0);                  // R7 erase-all
        do_read(1'b1, 77, 2, "R7 erase-all");
        do_ext(2'b00, 16'h0);                  // R7 disable
        do_write(1'b1, 4, 16'h0000, "R8");
        do_read(1'b1, 4, 1, "R7 R8 disabled write");

        tick(10);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R10 watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule